// File: doc/BRIEF.md
# SPI Pin Routing and Configuration Register

This unit is the configuration and pad-routing layer of an SPI port. It holds four configuration bits, loaded from a simple write strobe with a readback path: a fault-detect enable, a single-wire driver enable, a stop-during-wait enable and a single-wire mode select. From these bits and the current role, master or slave, it works out which of the MOSI and MISO pads the port owns and drives. It also picks the pad that feeds received serial data to the shifter, and tells the pad logic whether the port uses the SS pin.

Four-wire operation uses MOSI and MISO as separate data lines. In single-wire operation a master sends and receives on MOSI, and a slave sends and receives on MISO. In both cases the pad's driver follows the driver-enable bit, and the other data pad is handed back to general use. The unit also has hooks into the rest of the port:
- a one-cycle abort pulse, raised when a write changes a bit that affects an active master transfer;
- a sticky mode-fault flag, raised when a master that watches SS sees it pulled low; the flag demotes the port to slave;
- a clock enable that stops serial clock generation during wait when the port is set up to do so.

Top module: `spi_pin_ctrl`

## Requirements
- R1: After reset every configuration bit is 0, the readback is 8'h00, the mode-fault flag is 0 and no abort is pending.
- R2: A write stores bit 4 (fault-detect enable), bit 3 (single-wire driver enable), bit 1 (stop in wait) and bit 0 (single-wire mode). Bits 7, 6, 5 and 2 ignore writes and read as 0. The readback is combinational from the stored bits.
- R3: With bit 0 clear, the port owns both data pads. A master drives MOSI, leaves MISO undriven and receives from MISO. A slave drives MISO, leaves MOSI undriven and receives from MOSI.
- R4: With bit 0 set, a master owns only MOSI, drives it only while bit 3 is 1, and receives from MOSI. MISO is released and undriven.
- R5: With bit 0 set, a slave owns only MISO, drives it only while bit 3 is 1, and receives from MISO. MOSI is released and undriven.
- R6: SS is used by the port in slave role at all times, and in master role only while bit 4 is 1.
- R7: A master write while the transfer-busy input is high, that changes bit 4 or bit 0, produces a high xfer_abort in the next cycle. The pulse lasts one cycle for that write.
- R8: A master write while busy that changes bit 3 aborts only if bit 0 was already set before the write.
- R9: No abort comes from a write that changes no abort-relevant bit, from a write while busy is low, or from a write in slave role.
- R10: A master with bit 4 set that samples SS low at a clock edge sets mode_fault from the next cycle. The flag stays set until fault_clr is high at an edge, and while it is set is_master is 0.
- R11: spi_clk_en is 0 exactly when bit 1 is set and wait_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Readback of the configuration byte |
| master_req | input | 1 | Role asked for by the rest of the port (1 = master) |
| xfer_busy | input | 1 | A transfer is in progress in the shifter |
| wait_req | input | 1 | System wait state |
| fault_clr | input | 1 | Clears the mode-fault flag |
| shift_out | input | 1 | Serial data from the shifter |
| rx_data | output | 1 | Serial data routed to the shifter |
| mosi_in | input | 1 | MOSI pad input |
| mosi_out | output | 1 | MOSI pad output value |
| mosi_oe | output | 1 | MOSI pad driver enable |
| mosi_own | output | 1 | MOSI pad belongs to the port |
| miso_in | input | 1 | MISO pad input |
| miso_out | output | 1 | MISO pad output value |
| miso_oe | output | 1 | MISO pad driver enable |
| miso_own | output | 1 | MISO pad belongs to the port |
| ss_in | input | 1 | SS pad input |
| ss_used | output | 1 | SS pad is used by the port |
| is_master | output | 1 | Effective role after mode-fault demotion |
| mode_fault | output | 1 | Sticky mode-fault flag |
| xfer_abort | output | 1 | Pulse that returns the shifter to idle |
| spi_clk_en | output | 1 | Enable for serial clock generation |

## Verification
The bench aims at the abort conditions. It changes the driver-enable bit in four-wire mode, where a design that ignores the mode would abort, and in single-wire mode, where a design that misses it would leave a corrupt transfer running. It also rewrites unchanged values and writes while idle or as slave, which would catch an abort raised on every write. It pulls SS low as a master with and without fault detection, then clears the flag. This catches a flag that is not sticky, one that does not demote the role, and one raised in a slave. A long random run compares pad ownership, driver enables and the receive pad in every cycle, so a swapped role or mode mapping shows up at once.

// File: rtl/spi_pin_ctrl.sv
module spi_pin_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       master_req,
  input  logic       xfer_busy,
  input  logic       wait_req,
  input  logic       fault_clr,
  input  logic       shift_out,
  output logic       rx_data,
  input  logic       mosi_in,
  output logic       mosi_out,
  output logic       mosi_oe,
  output logic       mosi_own,
  input  logic       miso_in,
  output logic       miso_out,
  output logic       miso_oe,
  output logic       miso_own,
  input  logic       ss_in,
  output logic       ss_used,
  output logic       is_master,
  output logic       mode_fault,
  output logic       xfer_abort,
  output logic       spi_clk_en
);
  localparam logic [7:0] KEEP_MASK = 8'h1B;

  logic [7:0] cfg_q;
  logic       fault_q, abort_q;
  logic       fd_en, one_wire_oe, stop_wait, one_wire;
  logic [7:0] diff, trig_mask;

  assign fd_en       = cfg_q[4];
  assign one_wire_oe = cfg_q[3];
  assign stop_wait   = cfg_q[1];
  assign one_wire    = cfg_q[0];

  assign cfg_rdata  = cfg_q;
  assign is_master  = master_req & ~fault_q;
  assign mode_fault = fault_q;
  assign xfer_abort = abort_q;
  assign spi_clk_en = ~(stop_wait & wait_req);
  assign ss_used    = ~is_master | fd_en;

  assign mosi_out = shift_out;
  assign miso_out = shift_out;
  assign mosi_own = ~one_wire | is_master;
  assign miso_own = ~one_wire | ~is_master;
  assign mosi_oe  = is_master & (~one_wire | one_wire_oe);
  assign miso_oe  = ~is_master & (~one_wire | one_wire_oe);
  assign rx_data  = (is_master ^ one_wire) ? miso_in : mosi_in;

  assign diff      = (cfg_wdata & KEEP_MASK) ^ cfg_q;
  assign trig_mask = {4'b0001, one_wire, 2'b00, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= 8'h00;
      fault_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_wdata & KEEP_MASK;
      abort_q <= cfg_wr & is_master & xfer_busy & |(diff & trig_mask);
      fault_q <= (is_master & fd_en & ~ss_in) | (fault_q & ~fault_clr);
    end
  end

  a_r3_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    !(mosi_oe && miso_oe));
  a_r6_slave_ss: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> ss_used);
  a_r9_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |-> ($past(cfg_wr) && $past(xfer_busy) && $past(is_master)));
  a_r9_same_value: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_rdata == (cfg_wdata & 8'h1B)) |=> !xfer_abort);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_fault && !fault_clr) |=> mode_fault);
  a_r10_demote: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |-> !is_master);
  a_r11_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_clk_en |-> wait_req);
endmodule

// File: tb/tb_spi_pin_ctrl.sv
module tb_spi_pin_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, master_req = 0, xfer_busy = 0, wait_req = 0, fault_clr = 0;
  logic shift_out = 0, mosi_in = 0, miso_in = 0, ss_in = 1;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic rx_data, mosi_out, mosi_oe, mosi_own, miso_out, miso_oe, miso_own;
  logic ss_used, is_master, mode_fault, xfer_abort, spi_clk_en;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_pin_ctrl dut (.*);

  // behavioural reference state
  bit m_fd, m_oe, m_sw, m_ow, m_abort, m_fault;

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_fd, m_oe, m_sw, m_ow, m_abort, m_fault} = 6'b0;
    end else begin
      bit mst, ab, nf;
      mst = master_req && !m_fault;
      ab = 0;
      if (cfg_wr && mst && xfer_busy) begin
        if (cfg_wdata[4] != m_fd || cfg_wdata[0] != m_ow) ab = 1;
        if (m_ow && cfg_wdata[3] != m_oe) ab = 1;
      end
      nf = (mst && m_fd && !ss_in) || (m_fault && !fault_clr);
      if (cfg_wr) begin
        m_fd = cfg_wdata[4]; m_oe = cfg_wdata[3];
        m_sw = cfg_wdata[1]; m_ow = cfg_wdata[0];
      end
      m_abort = ab;
      m_fault = nf;
    end
  end

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit mst;
    string rt;
    mst = master_req && !m_fault;
    rt = m_ow ? (mst ? "R4" : "R5") : "R3";
    chk("R2", "cfg_rdata", cfg_rdata, {3'b0, m_fd, m_oe, 1'b0, m_sw, m_ow});
    chk("R10", "is_master", is_master, mst);
    chk("R10", "mode_fault", mode_fault, m_fault);
    chk("R7", "xfer_abort", xfer_abort, m_abort);
    chk("R11", "spi_clk_en", spi_clk_en, !(m_sw && wait_req));
    chk("R6", "ss_used", ss_used, !mst || m_fd);
    chk(rt, "mosi_own", mosi_own, !m_ow || mst);
    chk(rt, "miso_own", miso_own, !m_ow || !mst);
    chk(rt, "mosi_oe", mosi_oe, m_ow ? (mst && m_oe) : mst);
    chk(rt, "miso_oe", miso_oe, m_ow ? (!mst && m_oe) : !mst);
    chk(rt, "mosi_out", mosi_out, shift_out);
    chk(rt, "miso_out", miso_out, shift_out);
    chk(rt, "rx_data", rx_data, m_ow ? (mst ? mosi_in : miso_in) : (mst ? miso_in : mosi_in));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    cfg_wr = 0; fault_clr = 0;
  endtask

  task automatic wr(logic [7:0] v);
    cfg_wdata = v; cfg_wr = 1; tick();
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk("R1", "reset rdata", cfg_rdata, 8'h00);
    chk("R1", "reset fault", mode_fault, 0);
    chk("R1", "reset abort", xfer_abort, 0);
    rst_n = 1;
    tick();

    // R2 reserved bits
    wr(8'hFF); chk("R2", "masked write", cfg_rdata, 8'h1B);
    wr(8'h24); chk("R2", "reserved only", cfg_rdata, 8'h00);

    // R3 four-wire, both roles
    master_req = 1; miso_in = 1; mosi_in = 0; shift_out = 1; tick();
    chk("R3", "master rx from miso", rx_data, 1);
    chk("R3", "master mosi drive", mosi_oe, 1);
    master_req = 0; tick();
    chk("R3", "slave rx from mosi", rx_data, 0);
    chk("R3", "slave miso drive", miso_oe, 1);

    // R4 single-wire master
    master_req = 1; wr(8'h01);
    chk("R4", "oe off", mosi_oe, 0);
    chk("R4", "miso released", miso_own, 0);
    mosi_in = 1; miso_in = 0; tick();
    chk("R4", "rx from mosi", rx_data, 1);
    wr(8'h09); chk("R4", "oe on", mosi_oe, 1);

    // R5 single-wire slave
    master_req = 0; tick();
    chk("R5", "miso drive", miso_oe, 1);
    chk("R5", "mosi released", mosi_own, 0);
    chk("R5", "rx from miso", rx_data, 0);

    // R6 ss usage
    master_req = 1; wr(8'h00); chk("R6", "master no fd", ss_used, 0);
    wr(8'h10); chk("R6", "master fd", ss_used, 1);
    wr(8'h00);

    // R7 abort on fd / mode change
    xfer_busy = 1;
    wr(8'h10); chk("R7", "fd change abort", xfer_abort, 1);
    tick();    chk("R7", "pulse ends", xfer_abort, 0);
    wr(8'h11); chk("R7", "mode change abort", xfer_abort, 1);

    // R8 driver-enable change
    wr(8'h19); chk("R8", "oe change in single-wire", xfer_abort, 1);
    wr(8'h18); chk("R8", "mode change", xfer_abort, 1);
    wr(8'h10); chk("R8", "oe change four-wire", xfer_abort, 0);

    // R9 no-abort cases
    wr(8'h10); chk("R9", "same value", xfer_abort, 0);
    wr(8'h12); chk("R9", "stop-wait only", xfer_abort, 0);
    xfer_busy = 0; wr(8'h00); chk("R9", "idle write", xfer_abort, 0);
    xfer_busy = 1; master_req = 0; wr(8'h11); chk("R9", "slave write", xfer_abort, 0);
    master_req = 1; tick();

    // R10 mode fault
    ss_in = 0; tick(); chk("R10", "fault set", mode_fault, 1);
    chk("R10", "demoted", is_master, 0);
    ss_in = 1; repeat (3) tick(); chk("R10", "sticky", mode_fault, 1);
    fault_clr = 1; tick(); chk("R10", "cleared", mode_fault, 0);
    chk("R10", "master again", is_master, 1);
    xfer_busy = 0; wr(8'h01); ss_in = 0; tick(); chk("R10", "no fd no fault", mode_fault, 0);
    master_req = 0; wr(8'h10); tick(); chk("R10", "slave no fault", mode_fault, 0);
    ss_in = 1;

    // R11 clock enable
    wr(8'h02); wait_req = 1; tick(); chk("R11", "stopped", spi_clk_en, 0);
    wait_req = 0; tick(); chk("R11", "no wait", spi_clk_en, 1);
    wr(8'h00); wait_req = 1; tick(); chk("R11", "bit clear", spi_clk_en, 1);

    // random phase, compared every cycle
    for (int i = 0; i < 3000; i++) begin
      cfg_wr = ($urandom_range(0, 3) == 0);
      cfg_wdata = $urandom_range(0, 255);
      master_req = ($urandom_range(0, 3) != 0);
      xfer_busy = $urandom_range(0, 1);
      wait_req = $urandom_range(0, 1);
      fault_clr = ($urandom_range(0, 7) == 0);
      ss_in = ($urandom_range(0, 9) != 0);
      shift_out = $urandom_range(0, 1);
      mosi_in = $urandom_range(0, 1);
      miso_in = $urandom_range(0, 1);
      @(posedge clk);
      @(negedge clk);
      compare_all();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule